// File: doc/BRIEF.md
# Hierarchical State-Enable Register File and Access Checker

This block holds three banks of state-enable registers for a 64-bit hart: a machine bank, a hypervisor bank and a supervisor bank, each with four registers. Each bank gates the bank below it. Every register read is masked by the enable bits of all higher levels, so a lower level can never see or set a bit that a higher level has withheld.

For each request, the block decodes the CSR address and checks it against the current privilege mode and virtualization state. It then either completes the access or raises one trap flag. Denials that come from the hypervisor level, or from guest access to hypervisor-owned state, give a virtual-instruction trap. Denials from the machine level, or from plain user mode, give an illegal-instruction trap.

When floating-point registers are absent, the block also screens floating-point instructions against the enable bit that gates the FP control/status register. The trap flags and the read data are combinational. A permitted write takes effect at the next rising clock edge.

Top module: `stateen_access_unit`

## Requirements
- R1: After reset, every register of all three banks reads as zero from M mode.
- R2: The machine registers occupy addresses 0x30C to 0x30F. A write from M mode stores only the implemented bits:
  - register 0 implements bits 63, 62, 60, 59, 58, 57, 2, 1 and 0 (mask 0xDE00000000000007);
  - registers 1 to 3 implement bit 63 only.
  Unimplemented bits read as zero.
- R3: The mode input is coded as U=0, HS=1, M=3, VU=4 and VS=5; bit 2 set means virtualized. An access to a machine register from any mode other than M raises the illegal-instruction flag and changes nothing.
- R4: The hypervisor registers occupy addresses 0x60C to 0x60F. Each reads as its stored value ANDed with the machine register of the same index. A write changes only the bits that are set in that machine register.
- R5: Access to a hypervisor register is always permitted from M mode. From HS mode it is permitted only if bit 63 of the machine register with the same index is set; otherwise it is illegal. From U mode it is illegal. From VS or VU mode it is illegal when that machine bit 63 is clear, and raises a virtual-instruction trap otherwise.
- R6: The supervisor registers occupy addresses 0x10C to 0x10F. Bit 63 always reads zero. The read value is the stored value ANDed with the machine register and, in VS mode, also ANDed with the hypervisor register.
- R7: Supervisor register access rules:
  - M mode: always permitted.
  - HS mode: needs bit 63 of the machine register, otherwise illegal.
  - VS mode: illegal if machine bit 63 is clear; otherwise a virtual-instruction trap if hypervisor bit 63 is clear.
  - U mode: illegal.
  - VU mode: illegal if machine bit 63 is clear; otherwise a virtual-instruction trap.
- R8: A supervisor write from VS mode leaves unchanged every bit that is zero in the effective hypervisor register.
- R9: While FP registers are present, bit 1 of machine register 0 reads as zero and ignores writes.
- R10: A floating-point instruction (fp_insn_i) while FP registers are absent is checked in order, outside M mode:
  - illegal if bit 1 of machine register 0 is clear;
  - otherwise, in VS or VU mode, a virtual-instruction trap if bit 1 of hypervisor register 0 is clear;
  - otherwise, in U or VU mode, illegal if bit 1 of the effective supervisor register 0 is clear.
  With FP registers present, no such trap is raised.
- R11: A trapped access writes nothing and returns zero read data. An address outside the three banks raises no trap and reads zero.
- R12: The illegal-instruction and virtual-instruction flags are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Current privilege mode and virtualization bit |
| csr_addr_i | input | 12 | CSR address of the access |
| csr_rd_i | input | 1 | Read strobe |
| csr_wr_i | input | 1 | Write strobe |
| csr_wdata_i | input | 64 | Write data |
| fp_insn_i | input | 1 | A floating-point instruction is being issued |
| fp_present_i | input | 1 | Floating-point registers are implemented |
| csr_rdata_o | output | 64 | Read data; zero unless a permitted read hits a bank |
| illegal_o | output | 1 | Illegal-instruction trap |
| virt_o | output | 1 | Virtual-instruction trap |

## Verification
The assertions assume that the mode input carries one of the five defined codes, that the CSR address and strobes are stable around the clock edge, and that a write strobe is present only for the one cycle of its access. The stimulus changes every input only on the falling edge, uses only the five legal mode codes, and issues one access per cycle. It also routes floating-point instructions without a CSR strobe, so the CSR decode and the FP screen are exercised separately.

// File: rtl/stateen_pkg.sv
package stateen_pkg;
  typedef enum logic [2:0] {
    MODE_U  = 3'b000,
    MODE_HS = 3'b001,
    MODE_M  = 3'b011,
    MODE_VU = 3'b100,
    MODE_VS = 3'b101
  } mode_e;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_M    = 2'd1,
    LVL_H    = 2'd2,
    LVL_S    = 2'd3
  } lvl_e;

  localparam logic [11:0] M_BASE = 12'h30C;
  localparam logic [11:0] H_BASE = 12'h60C;
  localparam logic [11:0] S_BASE = 12'h10C;
  localparam int unsigned FP_BIT = 1;
endpackage

// File: rtl/stateen_bank.sv
module stateen_bank #(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned NUM_REGS = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [NUM_REGS-1:0]                we_i,
  input  logic [XLEN-1:0]                    wdata_i,
  input  logic [XLEN-1:0]                    wmask_i,
  output logic [NUM_REGS-1:0][XLEN-1:0]      q_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[g] <= '0;
      else if (we_i[g]) q_o[g] <= (q_o[g] & ~wmask_i) | (wdata_i & wmask_i);
    end
  end
endmodule

// File: rtl/stateen_check.sv
module stateen_check
  import stateen_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned IW       = 2
) (
  input  mode_e               mode_i,
  input  lvl_e                lvl_i,
  input  logic [IW-1:0]       idx_i,
  input  logic                req_i,
  input  logic                fp_insn_i,
  input  logic                fp_present_i,
  input  logic [NUM_REGS-1:0] m_gate_i,
  input  logic [NUM_REGS-1:0] h_gate_i,
  input  logic                m_fp_i,
  input  logic                h_fp_i,
  input  logic                s_fp_i,
  output logic                illegal_o,
  output logic                virt_o
);
  logic ill, vi, mg, hg, is_virt, is_user;

  assign mg      = m_gate_i[idx_i];
  assign hg      = h_gate_i[idx_i];
  assign is_virt = (mode_i == MODE_VS) || (mode_i == MODE_VU);
  assign is_user = (mode_i == MODE_U) || (mode_i == MODE_VU);

  always_comb begin
    ill = 1'b0;
    vi  = 1'b0;
    if (req_i) begin
      case (lvl_i)
        LVL_M: ill = (mode_i != MODE_M);
        LVL_H: begin
          if (mode_i == MODE_HS) ill = !mg;
          else if (mode_i == MODE_U) ill = 1'b1;
          else if (mode_i != MODE_M) begin
            ill = !mg;
            vi  = mg;
          end
        end
        LVL_S: begin
          if (mode_i == MODE_HS) ill = !mg;
          else if (mode_i == MODE_U) ill = 1'b1;
          else if (mode_i == MODE_VS) begin
            ill = !mg;
            vi  = mg && !hg;
          end else if (mode_i != MODE_M) begin
            ill = !mg;
            vi  = mg;
          end
        end
        default: ;
      endcase
    end
    // fp instructions act as fcsr accesses when fp registers are absent
    if (fp_insn_i && !fp_present_i && mode_i != MODE_M) begin
      if (!m_fp_i) ill = 1'b1;
      else if (is_virt && !h_fp_i) vi = 1'b1;
      else if (is_user && !s_fp_i) ill = 1'b1;
    end
  end

  assign illegal_o = ill;
  assign virt_o    = vi && !ill;
endmodule

// File: rtl/stateen_access_unit.sv
module stateen_access_unit
  import stateen_pkg::*;
#(
  parameter int unsigned     XLEN     = 64,
  parameter int unsigned     NUM_REGS = 4,
  parameter logic [XLEN-1:0] IMPL0    = 64'hDE00_0000_0000_0007,
  parameter logic [XLEN-1:0] IMPLN    = 64'h8000_0000_0000_0000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [2:0]      mode_i,
  input  logic [11:0]     csr_addr_i,
  input  logic            csr_rd_i,
  input  logic            csr_wr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  input  logic            fp_insn_i,
  input  logic            fp_present_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            illegal_o,
  output logic            virt_o
);
  localparam int unsigned     IW       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [11:0]     NUM12    = 12'(NUM_REGS);
  localparam logic [XLEN-1:0] GATE_ONE = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] FP_ONE   = XLEN'(1) << FP_BIT;

  mode_e mode;
  lvl_e  lvl;
  logic [IW-1:0] idx;
  logic req, ok, is_virt;

  logic [NUM_REGS-1:0][XLEN-1:0] m_q, h_q, s_q;
  logic [NUM_REGS-1:0][XLEN-1:0] m_mask, m_eff, h_eff, s_wm;
  logic [NUM_REGS-1:0] m_gate, h_gate, m_we, h_we, s_we, sel;

  assign mode    = mode_e'(mode_i);
  assign is_virt = mode_i[2];
  assign req     = csr_rd_i || csr_wr_i;

  always_comb begin
    lvl = LVL_NONE;
    idx = '0;
    if (csr_addr_i >= M_BASE && csr_addr_i < M_BASE + NUM12) begin
      lvl = LVL_M;
      idx = IW'(csr_addr_i - M_BASE);
    end else if (csr_addr_i >= H_BASE && csr_addr_i < H_BASE + NUM12) begin
      lvl = LVL_H;
      idx = IW'(csr_addr_i - H_BASE);
    end else if (csr_addr_i >= S_BASE && csr_addr_i < S_BASE + NUM12) begin
      lvl = LVL_S;
      idx = IW'(csr_addr_i - S_BASE);
    end
  end

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_eff
    localparam logic [XLEN-1:0] IMPL_K = (k == 0) ? IMPL0 : IMPLN;
    assign m_mask[k] = IMPL_K & ~((k == 0 && fp_present_i) ? FP_ONE : '0);
    assign m_eff[k]  = m_q[k] & m_mask[k];
    assign h_eff[k]  = h_q[k] & m_eff[k];
    // supervisor has no lower level, so its top bit is never implemented
    assign s_wm[k]   = IMPL_K & ~GATE_ONE & m_eff[k] & (is_virt ? h_eff[k] : '1);
    assign m_gate[k] = m_eff[k][XLEN-1];
    assign h_gate[k] = h_eff[k][XLEN-1];
  end

  stateen_check #(.NUM_REGS(NUM_REGS), .IW(IW)) u_check (
    .mode_i       (mode),
    .lvl_i        (lvl),
    .idx_i        (idx),
    .req_i        (req),
    .fp_insn_i    (fp_insn_i),
    .fp_present_i (fp_present_i),
    .m_gate_i     (m_gate),
    .h_gate_i     (h_gate),
    .m_fp_i       (m_eff[0][FP_BIT]),
    .h_fp_i       (h_eff[0][FP_BIT]),
    .s_fp_i       (s_q[0][FP_BIT] & s_wm[0][FP_BIT]),
    .illegal_o    (illegal_o),
    .virt_o       (virt_o)
  );

  assign ok   = req && (lvl != LVL_NONE) && !illegal_o && !virt_o;
  assign sel  = NUM_REGS'(1) << idx;
  assign m_we = (ok && csr_wr_i && lvl == LVL_M) ? sel : '0;
  assign h_we = (ok && csr_wr_i && lvl == LVL_H) ? sel : '0;
  assign s_we = (ok && csr_wr_i && lvl == LVL_S) ? sel : '0;

  always_comb begin
    csr_rdata_o = '0;
    if (ok && csr_rd_i) begin
      case (lvl)
        LVL_M:   csr_rdata_o = m_eff[idx];
        LVL_H:   csr_rdata_o = h_eff[idx];
        LVL_S:   csr_rdata_o = s_q[idx] & s_wm[idx];
        default: csr_rdata_o = '0;
      endcase
    end
  end

  stateen_bank #(.XLEN(XLEN), .NUM_REGS(NUM_REGS)) u_m_bank (
    .clk_i (clk_i), .rst_ni (rst_ni), .we_i (m_we),
    .wdata_i (csr_wdata_i), .wmask_i (m_mask[idx]), .q_o (m_q)
  );
  stateen_bank #(.XLEN(XLEN), .NUM_REGS(NUM_REGS)) u_h_bank (
    .clk_i (clk_i), .rst_ni (rst_ni), .we_i (h_we),
    .wdata_i (csr_wdata_i), .wmask_i (m_eff[idx]), .q_o (h_q)
  );
  stateen_bank #(.XLEN(XLEN), .NUM_REGS(NUM_REGS)) u_s_bank (
    .clk_i (clk_i), .rst_ni (rst_ni), .we_i (s_we),
    .wdata_i (csr_wdata_i), .wmask_i (s_wm[idx]), .q_o (s_q)
  );
endmodule

// File: rtl/stateen_access_sva.sv
module stateen_access_sva
  import stateen_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned NUM_REGS = 4
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [2:0]                    mode_i,
  input logic [11:0]                   csr_addr_i,
  input logic                          csr_rd_i,
  input logic                          csr_wr_i,
  input logic [XLEN-1:0]               csr_rdata_o,
  input logic                          illegal_o,
  input logic                          virt_o,
  input logic [NUM_REGS-1:0][XLEN-1:0] m_q,
  input logic [NUM_REGS-1:0][XLEN-1:0] h_q,
  input logic [NUM_REGS-1:0][XLEN-1:0] s_q
);
  localparam int unsigned IW    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [11:0] NUM12 = 12'(NUM_REGS);

  logic req, in_m, in_h, in_s;
  logic [IW-1:0] h_idx;

  assign req   = csr_rd_i || csr_wr_i;
  assign in_m  = csr_addr_i >= M_BASE && csr_addr_i < M_BASE + NUM12;
  assign in_h  = csr_addr_i >= H_BASE && csr_addr_i < H_BASE + NUM12;
  assign in_s  = csr_addr_i >= S_BASE && csr_addr_i < S_BASE + NUM12;
  assign h_idx = IW'(csr_addr_i - H_BASE);

  p_trap_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(illegal_o && virt_o));

  p_m_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req && in_m && mode_i != 3'b011) |-> illegal_o);

  p_h_guest_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req && in_h && mode_i[2]) |-> (illegal_o || virt_o));

  p_s_top_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_rd_i && in_s && !illegal_o && !virt_o) |-> !csr_rdata_o[XLEN-1]);

  p_h_within_m_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_rd_i && in_h && !illegal_o && !virt_o) |-> ((csr_rdata_o & ~m_q[h_idx]) == '0));

  p_trap_no_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_wr_i && (illegal_o || virt_o)) |=> ($stable(m_q) && $stable(h_q) && $stable(s_q)));
endmodule

bind stateen_access_unit stateen_access_sva #(.XLEN(XLEN), .NUM_REGS(NUM_REGS)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .csr_addr_i  (csr_addr_i),
  .csr_rd_i    (csr_rd_i),
  .csr_wr_i    (csr_wr_i),
  .csr_rdata_o (csr_rdata_o),
  .illegal_o   (illegal_o),
  .virt_o      (virt_o),
  .m_q         (m_q),
  .h_q         (h_q),
  .s_q         (s_q)
);

// File: tb/stateen_access_unit_test.sv
module stateen_access_unit_test;
  localparam logic [2:0] U = 3'b000, HS = 3'b001, M = 3'b011, VU = 3'b100, VS = 3'b101;
  localparam logic [63:0] A    = 64'hDE00_0000_0000_0007;
  localparam logic [63:0] SA   = 64'h5E00_0000_0000_0007;
  localparam logic [63:0] G    = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONES = '1;

  typedef struct packed {
    logic [63:0] rd;
    logic        ill;
    logic        vi;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [2:0]  mode_i;
  logic [11:0] csr_addr_i;
  logic        csr_rd_i, csr_wr_i, fp_insn_i, fp_present_i;
  logic [63:0] csr_wdata_i, csr_rdata_o;
  logic        illegal_o, virt_o;
  logic        fp_cfg = 1'b0;
  logic        done = 1'b0;
  int          checks = 0;
  int          errors = 0;
  exp_t        exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  stateen_access_unit uut (
    .clk_i (clk), .rst_ni (rst_ni), .mode_i (mode_i), .csr_addr_i (csr_addr_i),
    .csr_rd_i (csr_rd_i), .csr_wr_i (csr_wr_i), .csr_wdata_i (csr_wdata_i),
    .fp_insn_i (fp_insn_i), .fp_present_i (fp_present_i),
    .csr_rdata_o (csr_rdata_o), .illegal_o (illegal_o), .virt_o (virt_o)
  );

  task automatic op(input logic [2:0] md, input logic [11:0] ad, input logic rd, input logic wr,
                    input logic [63:0] wd, input logic fpi, input logic [63:0] erd,
                    input logic eill, input logic evi, input string tag);
    exp_t e;
    @(negedge clk);
    mode_i = md; csr_addr_i = ad; csr_rd_i = rd; csr_wr_i = wr;
    csr_wdata_i = wd; fp_insn_i = fpi; fp_present_i = fp_cfg;
    e.rd = erd; e.ill = eill; e.vi = evi;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: samples mid-low-phase, after inputs settle
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (csr_rdata_o !== e.rd || illegal_o !== e.ill || virt_o !== e.vi) begin
          errors++;
          $display("FAIL %s: got rd=%h ill=%b vi=%b, expected rd=%h ill=%b vi=%b",
                   t, csr_rdata_o, illegal_o, virt_o, e.rd, e.ill, e.vi);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    mode_i = M; csr_addr_i = '0; csr_rd_i = 0; csr_wr_i = 0;
    csr_wdata_i = '0; fp_insn_i = 0; fp_present_i = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    op(M,  12'h30C, 1, 0, 0, 0, 0, 0, 0, "R1 m0 reset");
    op(M,  12'h10C, 1, 0, 0, 0, 0, 0, 0, "R1 s0 reset");
    op(M,  12'h30C, 0, 1, ONES, 0, 0, 0, 0, "R2 m0 write");
    op(M,  12'h30C, 1, 0, 0, 0, A, 0, 0, "R2 m0 impl mask");
    op(M,  12'h30D, 0, 1, ONES, 0, 0, 0, 0, "R2 m1 write");
    op(M,  12'h30D, 1, 0, 0, 0, G, 0, 0, "R2 m1 impl mask");
    op(HS, 12'h30C, 0, 1, 0, 0, 0, 1, 0, "R3 m0 from HS");
    op(M,  12'h30C, 1, 0, 0, 0, A, 0, 0, "R3 R11 m0 unchanged");
    op(VS, 12'h30D, 1, 0, 0, 0, 0, 1, 0, "R3 m1 from VS");
    op(HS, 12'h60C, 0, 1, ONES, 0, 0, 0, 0, "R5 h0 write HS");
    op(HS, 12'h60C, 1, 0, 0, 0, A, 0, 0, "R5 h0 read HS");
    op(M,  12'h30C, 0, 1, 64'h8000_0000_0000_0001, 0, 0, 0, 0, "R4 narrow m0");
    op(M,  12'h60C, 1, 0, 0, 0, 64'h8000_0000_0000_0001, 0, 0, "R4 h0 masked by m0");
    op(M,  12'h60C, 0, 1, 0, 0, 0, 0, 0, "R4 h0 partial write");
    op(M,  12'h30C, 0, 1, ONES, 0, 0, 0, 0, "R4 widen m0");
    op(HS, 12'h60C, 1, 0, 0, 0, 64'h5E00_0000_0000_0006, 0, 0, "R4 h0 kept bits");
    op(U,  12'h60C, 1, 0, 0, 0, 0, 1, 0, "R5 h0 from U");
    op(VS, 12'h60D, 1, 0, 0, 0, 0, 0, 1, "R5 R12 h1 from VS");
    op(HS, 12'h60D, 1, 0, 0, 0, 0, 0, 0, "R5 h1 from HS");
    op(HS, 12'h60E, 1, 0, 0, 0, 0, 1, 0, "R5 h2 gate clear HS");
    op(VU, 12'h60E, 1, 0, 0, 0, 0, 1, 0, "R5 R12 h2 gate clear VU");
    op(HS, 12'h10C, 0, 1, ONES, 0, 0, 0, 0, "R6 s0 write HS");
    op(HS, 12'h10C, 1, 0, 0, 0, SA, 0, 0, "R6 s0 top bit zero");
    op(VS, 12'h10C, 1, 0, 0, 0, 0, 0, 1, "R7 s0 VS h gate clear");
    op(HS, 12'h60C, 0, 1, ONES, 0, 0, 0, 0, "R7 h0 open");
    op(VS, 12'h10C, 1, 0, 0, 0, SA, 0, 0, "R6 s0 from VS");
    op(HS, 12'h60C, 0, 1, G, 0, 0, 0, 0, "R6 h0 gate only");
    op(VS, 12'h10C, 1, 0, 0, 0, 0, 0, 0, "R6 s0 masked by h0");
    op(VS, 12'h10C, 0, 1, 0, 0, 0, 0, 0, "R8 s0 VS write masked");
    op(HS, 12'h10C, 1, 0, 0, 0, SA, 0, 0, "R8 s0 preserved");
    op(HS, 12'h60C, 0, 1, G | 64'd1, 0, 0, 0, 0, "R8 h0 expose bit0");
    op(VS, 12'h10C, 0, 1, 0, 0, 0, 0, 0, "R8 s0 VS clear bit0");
    op(HS, 12'h10C, 1, 0, 0, 0, 64'h5E00_0000_0000_0006, 0, 0, "R8 s0 only bit0 cleared");
    op(U,  12'h10C, 1, 0, 0, 0, 0, 1, 0, "R7 s0 from U");
    op(VU, 12'h10C, 1, 0, 0, 0, 0, 0, 1, "R7 R12 s0 from VU");
    op(HS, 12'h10F, 1, 0, 0, 0, 0, 1, 0, "R7 s3 gate clear");
    op(HS, 12'h000, 0, 0, 0, 1, 0, 0, 0, "R10 fp HS allowed");
    op(U,  12'h000, 0, 0, 0, 1, 0, 0, 0, "R10 fp U allowed");
    op(VS, 12'h000, 0, 0, 0, 1, 0, 0, 1, "R10 R12 fp VS h bit clear");
    op(M,  12'h30C, 0, 1, 64'hDE00_0000_0000_0005, 0, 0, 0, 0, "R10 m0 fp bit clear");
    op(HS, 12'h000, 0, 0, 0, 1, 0, 1, 0, "R10 fp HS m bit clear");
    op(M,  12'h000, 0, 0, 0, 1, 0, 0, 0, "R10 fp M exempt");
    op(M,  12'h30C, 0, 1, ONES, 0, 0, 0, 0, "R10 m0 reopen");
    op(HS, 12'h10C, 0, 1, 0, 0, 0, 0, 0, "R10 s0 clear");
    op(U,  12'h000, 0, 0, 0, 1, 0, 1, 0, "R10 fp U s bit clear");
    fp_cfg = 1'b1;
    op(M,  12'h30C, 0, 1, ONES, 0, 0, 0, 0, "R9 m0 write fp present");
    op(M,  12'h30C, 1, 0, 0, 0, 64'hDE00_0000_0000_0005, 0, 0, "R9 fp bit read zero");
    op(HS, 12'h000, 0, 0, 0, 1, 0, 0, 0, "R10 fp present no trap");
    op(U,  12'h300, 1, 0, 0, 0, 0, 0, 0, "R11 unrelated read");
    op(VS, 12'h123, 0, 1, ONES, 0, 0, 0, 0, "R11 unrelated write");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule